// File: doc/BRIEF.md
# Channel Sample Packer with Event Trailer

This block turns a stream of 10-bit samples, delivered channel by channel, into a stream of 32-bit words. A channel's samples are gathered three to a word and held in a local word buffer. When the channel ends, the block emits one channel header word and then the buffered sample words. A two-bit tag in bits 31:30 of every output word tells a downstream parser what kind of word it is.

On the last sample of each channel, the sample source also presents two things. The first is the channel address and sample count that the channel reported about itself. The second is the channel address the system expected. The block builds the header from the expected address and from the number of samples it actually counted. It raises an error bit in the header when either reported value disagrees, and it counts each kind of disagreement.

When the event is closed, the block appends a fixed nine-word trailer. The trailer carries:
- the number of header and sample words sent in the event,
- the two mismatch counts,
- six status and configuration values captured when the close is accepted,
- a final identity word with the firmware version, the unit address and the trailer length.

Closing an event clears the counts for the next event.

Top module: `evpk_event_packer`

## Requirements
- R1: Sample words carry tag 00 in bits 31:30. The first sample of a group of three sits in bits 29:20, the second in bits 19:10 and the third in bits 9:0, in arrival order.
- R2: When a channel ends part-way through a word, the unused sample fields of that last word are zero.
- R3: Each channel's output opens with one header word, followed by exactly ceil(n/3) sample words for n samples. The header has:
  - tag 01 in bits 31:30,
  - the expected channel address in bits 11:0,
  - the counted sample number n in bits 25:16,
  - zero in bits 28:26 and 15:12.
- R4: Header bit 29 is 1 when the channel-reported address differs from the expected address, or when the channel-reported length differs from the counted samples. Otherwise it is 0.
- R5: While header, sample or trailer words are pending on the output, `s_ready` is low. A word held under `m_ready` low stays valid and unchanged until it is taken.
- R6: A close request is accepted only when no channel is partly received. After it is accepted, nine trailer words follow, with codes 0 to 8 in bits 29:26, in order. Words with codes 0 to 7 carry tag 10. The code-8 word carries tag 11 and is the only word with `m_last` high.
- R7: The code-0 trailer value equals the number of header and sample words emitted since the previous trailer.
- R8: The code-3 trailer value holds the address-mismatch count in bits 11:0 and the length-mismatch count in bits 24:12. Both counts cover the channels since the previous trailer and saturate at their maximum.
- R9: The code-8 trailer value holds the firmware version in bits 25:16, the unit address in bits 15:7 and the trailer length 9 in bits 6:0.
- R10: Trailer codes 1, 2, 4, 5, 6 and 7 carry, in that order, `err_reg_a`, `err_reg_b`, `fec_list_a`, `fec_list_b`, `rdo_cfg_a` and `rdo_cfg_b`, together with `unit_addr`. All of these are the values present in the cycle the close is accepted.
- R11: A channel that reaches MAX_SAMP samples ends at that sample even without `s_last`. The channel-reported fields on the input at that sample are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high with s_valid |
| s_sample | input | 10 | Sample value |
| s_last | input | 1 | Marks the channel's final sample |
| s_exp_addr | input | 12 | Expected channel address, read at channel end |
| s_trl_addr | input | 12 | Address reported by the channel, read at channel end |
| s_trl_len | input | 10 | Sample count reported by the channel, read at channel end |
| close_valid | input | 1 | Request to close the event |
| close_ready | output | 1 | Close accepted when high with close_valid |
| err_reg_a | input | 26 | Trailer value, code 1 |
| err_reg_b | input | 26 | Trailer value, code 2 |
| fec_list_a | input | 26 | Trailer value, code 4 |
| fec_list_b | input | 26 | Trailer value, code 5 |
| rdo_cfg_a | input | 26 | Trailer value, code 6 |
| rdo_cfg_b | input | 26 | Trailer value, code 7 |
| unit_addr | input | 9 | Unit address for the final trailer word |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Output word taken when high with m_valid |
| m_data | output | 32 | Output word |
| m_last | output | 1 | High on the final trailer word |

## Verification
The bench builds the block with MAX_SAMP set to 16, so the word buffer is six entries deep. This lets a channel reach the sample limit within a few dozen cycles: 16 samples fill five whole words plus one word holding a single sample. That case exercises the forced channel end and the zero fill of a one-sample word together. The same channel runs against a pseudo-random `m_ready` pattern, so words are held under backpressure. FW_VER keeps its default value of 2, which is the value checked in the final trailer word.

// File: rtl/evpk_pkg.sv
package evpk_pkg;

   localparam int SAMP_W    = 10;
   localparam int ADDR_W    = 12;
   localparam int LEN_W     = 10;
   localparam int WORD_W    = 32;
   localparam int VAL_W     = 26;
   localparam int SLOTS     = 3;
   localparam int TRL_WORDS = 9;
   localparam int CODE_W    = 4;
   localparam int AMM_W     = 12;
   localparam int LMM_W     = 13;

   localparam logic [1:0] TAG_DATA = 2'b00;
   localparam logic [1:0] TAG_HDR  = 2'b01;
   localparam logic [1:0] TAG_TRL  = 2'b10;
   localparam logic [1:0] TAG_END  = 2'b11;

   typedef enum logic [1:0] {
      ST_FILL,
      ST_HDR,
      ST_DATA,
      ST_TRL
   } evpk_state_e;

   function automatic logic [WORD_W-1:0] make_hdr(input logic err,
                                                  input logic [LEN_W-1:0] len,
                                                  input logic [ADDR_W-1:0] addr);
      return {TAG_HDR, err, 3'b000, len, 4'b0000, addr};
   endfunction

   function automatic logic [WORD_W-1:0] make_trl(input logic fin,
                                                  input logic [CODE_W-1:0] code,
                                                  input logic [VAL_W-1:0] val);
      return {(fin ? TAG_END : TAG_TRL), code, val};
   endfunction

endpackage

// File: rtl/evpk_cnt.sv
module evpk_cnt #(
   parameter int W   = 12,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         inc,
   output logic [W-1:0] q
);
   logic [W-1:0] q_r;
   logic         step;

   generate
      if (SAT) begin : g_sat
         assign step = inc && !(&q_r);
      end else begin : g_wrap
         assign step = inc;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      q_r <= '0;
      else if (clear)  q_r <= '0;
      else if (step)   q_r <= q_r + 1'b1;
   end

   assign q = q_r;

   // R8 / R7: counts restart after each trailer
   p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (q == '0));

endmodule

// File: rtl/evpk_tally.sv
module evpk_tally
   import evpk_pkg::*;
#(
   parameter int PAY_W    = VAL_W,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             word_sent,
   input  logic             chan_done,
   input  logic             addr_mis,
   input  logic             len_mis,
   output logic [PAY_W-1:0] pay_cnt,
   output logic [AMM_W-1:0] addr_mm,
   output logic [LMM_W-1:0] len_mm
);
   evpk_cnt #(.W(PAY_W), .SAT(SATURATE)) u_pay (
      .clk(clk), .rst_n(rst_n), .clear(clear), .inc(word_sent), .q(pay_cnt));

   evpk_cnt #(.W(AMM_W), .SAT(SATURATE)) u_amm (
      .clk(clk), .rst_n(rst_n), .clear(clear), .inc(chan_done && addr_mis), .q(addr_mm));

   evpk_cnt #(.W(LMM_W), .SAT(SATURATE)) u_lmm (
      .clk(clk), .rst_n(rst_n), .clear(clear), .inc(chan_done && len_mis), .q(len_mm));

endmodule

// File: rtl/evpk_slot_packer.sv
module evpk_slot_packer
   import evpk_pkg::*;
#(
   parameter int  MAX_SAMP = 255,
   localparam int BUF_W    = (MAX_SAMP + SLOTS - 1) / SLOTS,
   localparam int IDX_W    = $clog2(BUF_W),
   localparam int NW_W     = $clog2(BUF_W + 1),
   localparam int CNT_W    = $clog2(MAX_SAMP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_en,
   input  logic              close_req,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [SAMP_W-1:0] s_sample,
   input  logic              s_last,
   input  logic [ADDR_W-1:0] s_exp_addr,
   input  logic [ADDR_W-1:0] s_trl_addr,
   input  logic [LEN_W-1:0]  s_trl_len,
   output logic              chan_done,
   output logic              addr_mis,
   output logic              len_mis,
   output logic              mid_chan,
   output logic [WORD_W-1:0] hdr_word,
   output logic [NW_W-1:0]   nwords,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_word
);
   localparam int LANES_W = SLOTS * SAMP_W;

   logic [CNT_W-1:0]   scnt;
   logic [CNT_W-1:0]   cnt_next;
   logic [1:0]         slot;
   logic [LANES_W-1:0] acc;
   logic [LANES_W-1:0] word_now;
   logic [IDX_W-1:0]   wcnt;
   logic               take;
   logic               end_chan;
   logic               flush;
   logic [WORD_W-1:0]  mem [BUF_W];

   assign mid_chan = (scnt != '0);
   assign s_ready  = fill_en && !(close_req && !mid_chan);
   assign take     = s_valid && s_ready;
   assign cnt_next = scnt + 1'b1;
   assign end_chan = take && (s_last || (cnt_next == CNT_W'(MAX_SAMP)));
   assign flush    = take && ((slot == 2'(SLOTS - 1)) || end_chan);

   assign chan_done = end_chan;
   assign addr_mis  = (s_trl_addr != s_exp_addr);
   assign len_mis   = (s_trl_len != LEN_W'(cnt_next));

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_lane
         localparam int LO = (SLOTS - 1 - k) * SAMP_W;
         assign word_now[LO +: SAMP_W] = (slot == 2'(k)) ? s_sample : acc[LO +: SAMP_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scnt     <= '0;
         slot     <= '0;
         acc      <= '0;
         wcnt     <= '0;
         nwords   <= '0;
         hdr_word <= '0;
      end else if (take) begin
         scnt <= end_chan ? '0 : cnt_next;
         if (flush) begin
            acc  <= '0;
            slot <= '0;
            wcnt <= end_chan ? '0 : wcnt + 1'b1;
         end else begin
            acc  <= word_now;
            slot <= slot + 1'b1;
         end
         if (end_chan) begin
            nwords   <= NW_W'(wcnt) + 1'b1;
            hdr_word <= make_hdr(addr_mis || len_mis, LEN_W'(cnt_next), s_exp_addr);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (flush) mem[wcnt] <= {TAG_DATA, word_now};
   end

   assign rd_word = mem[rd_idx];

   // R11: the channel never grows past the buffer
   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (scnt < CNT_W'(MAX_SAMP)));

   // R2: a new word always starts with empty lanes
   p_fresh_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (acc == '0));

endmodule

// File: rtl/evpk_event_packer.sv
module evpk_event_packer
   import evpk_pkg::*;
#(
   parameter int          MAX_SAMP = 255,
   parameter logic [9:0]  FW_VER   = 10'h002,
   parameter bit          SATURATE = 1'b1,
   localparam int         BUF_W    = (MAX_SAMP + SLOTS - 1) / SLOTS,
   localparam int         IDX_W    = $clog2(BUF_W),
   localparam int         NW_W     = $clog2(BUF_W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         s_valid,
   output logic         s_ready,
   input  logic [9:0]   s_sample,
   input  logic         s_last,
   input  logic [11:0]  s_exp_addr,
   input  logic [11:0]  s_trl_addr,
   input  logic [9:0]   s_trl_len,
   input  logic         close_valid,
   output logic         close_ready,
   input  logic [25:0]  err_reg_a,
   input  logic [25:0]  err_reg_b,
   input  logic [25:0]  fec_list_a,
   input  logic [25:0]  fec_list_b,
   input  logic [25:0]  rdo_cfg_a,
   input  logic [25:0]  rdo_cfg_b,
   input  logic [8:0]   unit_addr,
   output logic         m_valid,
   input  logic         m_ready,
   output logic [31:0]  m_data,
   output logic         m_last
);
   generate
      if (MAX_SAMP < 4 || MAX_SAMP > 1023) begin : g_bad_max
         $error("MAX_SAMP must lie in 4..1023");
      end
   endgenerate

   evpk_state_e       state_q;
   logic [IDX_W-1:0]  ridx_q;
   logic [3:0]        tidx_q;
   logic [VAL_W-1:0]  cfg_q [6];
   logic [8:0]        unit_q;

   logic              fill_en, close_take, hs, word_sent, trl_clear;
   logic              chan_done, addr_mis, len_mis, mid_chan;
   logic [WORD_W-1:0] hdr_word, rd_word;
   logic [NW_W-1:0]   nwords;
   logic [VAL_W-1:0]  pay_cnt;
   logic [AMM_W-1:0]  addr_mm;
   logic [LMM_W-1:0]  len_mm;
   logic [VAL_W-1:0]  trl_val;

   assign fill_en     = (state_q == ST_FILL);
   assign close_ready = fill_en && !mid_chan;
   assign close_take  = close_valid && close_ready;
   assign m_valid     = !fill_en;
   assign hs          = m_valid && m_ready;
   assign m_last      = (state_q == ST_TRL) && (tidx_q == 4'(TRL_WORDS - 1));
   assign word_sent   = hs && ((state_q == ST_HDR) || (state_q == ST_DATA));
   assign trl_clear   = hs && m_last;

   evpk_slot_packer #(.MAX_SAMP(MAX_SAMP)) u_pack (
      .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .close_req(close_valid),
      .s_valid(s_valid), .s_ready(s_ready), .s_sample(s_sample), .s_last(s_last),
      .s_exp_addr(s_exp_addr), .s_trl_addr(s_trl_addr), .s_trl_len(s_trl_len),
      .chan_done(chan_done), .addr_mis(addr_mis), .len_mis(len_mis),
      .mid_chan(mid_chan), .hdr_word(hdr_word), .nwords(nwords),
      .rd_idx(ridx_q), .rd_word(rd_word));

   evpk_tally #(.PAY_W(VAL_W), .SATURATE(SATURATE)) u_tally (
      .clk(clk), .rst_n(rst_n), .clear(trl_clear), .word_sent(word_sent),
      .chan_done(chan_done), .addr_mis(addr_mis), .len_mis(len_mis),
      .pay_cnt(pay_cnt), .addr_mm(addr_mm), .len_mm(len_mm));

   always_comb begin
      case (tidx_q)
         4'd0:    trl_val = pay_cnt;
         4'd1:    trl_val = cfg_q[0];
         4'd2:    trl_val = cfg_q[1];
         4'd3:    trl_val = {1'b0, len_mm, addr_mm};
         4'd4:    trl_val = cfg_q[2];
         4'd5:    trl_val = cfg_q[3];
         4'd6:    trl_val = cfg_q[4];
         4'd7:    trl_val = cfg_q[5];
         default: trl_val = {FW_VER, unit_q, 7'(TRL_WORDS)};
      endcase
   end

   always_comb begin
      case (state_q)
         ST_HDR:  m_data = hdr_word;
         ST_DATA: m_data = rd_word;
         ST_TRL:  m_data = make_trl(m_last, tidx_q, trl_val);
         default: m_data = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_FILL;
         ridx_q  <= '0;
         tidx_q  <= '0;
         unit_q  <= '0;
         for (int i = 0; i < 6; i++) cfg_q[i] <= '0;
      end else begin
         case (state_q)
            ST_FILL: begin
               if (close_take) begin
                  state_q  <= ST_TRL;
                  tidx_q   <= '0;
                  cfg_q[0] <= err_reg_a;
                  cfg_q[1] <= err_reg_b;
                  cfg_q[2] <= fec_list_a;
                  cfg_q[3] <= fec_list_b;
                  cfg_q[4] <= rdo_cfg_a;
                  cfg_q[5] <= rdo_cfg_b;
                  unit_q   <= unit_addr;
               end else if (chan_done) begin
                  state_q <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (hs) begin
                  state_q <= ST_DATA;
                  ridx_q  <= '0;
               end
            end
            ST_DATA: begin
               if (hs) begin
                  if (NW_W'(ridx_q) + 1'b1 == nwords) state_q <= ST_FILL;
                  else                               ridx_q  <= ridx_q + 1'b1;
               end
            end
            default: begin
               if (hs) begin
                  if (m_last) state_q <= ST_FILL;
                  else        tidx_q  <= tidx_q + 1'b1;
               end
            end
         endcase
      end
   end

   // R5: a held word stays put until taken
   p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

   // R5: input and output never active together
   p_in_out_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_ready && m_valid));

   // R6: the closing tag appears only on the flagged final word
   p_end_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && (m_data[31:30] == TAG_END)) |-> m_last);

   // R3: a header is always followed by a sample word
   p_hdr_then_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && (m_data[31:30] == TAG_HDR)) |=> (m_valid && (m_data[31:30] == TAG_DATA)));

endmodule

// File: tb/tb_evpk_event_packer.sv
module tb_evpk_event_packer;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_SAMP   = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid = 1'b0, s_ready, s_last = 1'b0;
   logic [9:0]  s_sample = '0;
   logic [11:0] s_exp_addr = '0, s_trl_addr = '0;
   logic [9:0]  s_trl_len = '0;
   logic        close_valid = 1'b0, close_ready;
   logic [25:0] err_reg_a = '0, err_reg_b = '0, fec_list_a = '0, fec_list_b = '0;
   logic [25:0] rdo_cfg_a = '0, rdo_cfg_b = '0;
   logic [8:0]  unit_addr = '0;
   logic        m_valid, m_ready = 1'b1, m_last;
   logic [31:0] m_data;

   int n_chk = 0, n_bad = 0;
   logic [31:0] cap_w [0:255];
   logic        cap_l [0:255];
   int          cap_n = 0;
   logic        bp_en = 1'b0;
   logic [3:0]  lf = 4'b1001;
   logic        prev_stall = 1'b0;
   logic [31:0] prev_data = '0;

   evpk_event_packer #(.MAX_SAMP(MAX_SAMP)) dut (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
      .s_sample(s_sample), .s_last(s_last), .s_exp_addr(s_exp_addr),
      .s_trl_addr(s_trl_addr), .s_trl_len(s_trl_len), .close_valid(close_valid),
      .close_ready(close_ready), .err_reg_a(err_reg_a), .err_reg_b(err_reg_b),
      .fec_list_a(fec_list_a), .fec_list_b(fec_list_b), .rdo_cfg_a(rdo_cfg_a),
      .rdo_cfg_b(rdo_cfg_b), .unit_addr(unit_addr), .m_valid(m_valid),
      .m_ready(m_ready), .m_data(m_data), .m_last(m_last));

   initial forever #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   // output capture and handshake rules, sampled mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall) begin
            chk("R5 held word valid", {31'b0, m_valid}, 32'd1);
            chk("R5 held word stable", m_data, prev_data);
         end
         if (s_ready && m_valid) chk("R5 s_ready low while output pending", 32'd1, 32'd0);
         if (m_valid && m_ready && cap_n < 256) begin
            cap_w[cap_n] = m_data;
            cap_l[cap_n] = m_last;
            cap_n++;
         end
         prev_stall = m_valid && !m_ready;
         prev_data  = m_data;
      end
   end

   initial forever begin
      @(posedge clk); #2;
      lf = {lf[2:0], lf[3] ^ lf[2]};
      m_ready = bp_en ? lf[0] : 1'b1;
   end

   task automatic send_samples(input int n, input int base, input bit with_last,
                               input logic [11:0] ea, input logic [11:0] ta,
                               input logic [9:0] tl);
      s_exp_addr = ea; s_trl_addr = ta; s_trl_len = tl;
      for (int i = 0; i < n; i++) begin
         logic got;
         s_valid  = 1'b1;
         s_sample = 10'(base + i);
         s_last   = with_last && (i == n - 1);
         do begin
            @(negedge clk); got = s_ready;
            @(posedge clk); #2;
         end while (!got);
      end
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic wait_caps(input int n);
      while (cap_n < n) @(posedge clk);
   endtask

   task automatic set_cfg(input logic [25:0] v);
      err_reg_a  = v ^ 26'h0ABCDEF;  err_reg_b  = v ^ 26'h1234567;
      fec_list_a = v ^ 26'h000FFFF;  fec_list_b = v ^ 26'h3FF0000;
      rdo_cfg_a  = v ^ 26'h2AAAAAA;  rdo_cfg_b  = v ^ 26'h1555555;
      unit_addr  = v[8:0] ^ 9'h1A5;
   endtask

   task automatic do_close();
      logic got;
      close_valid = 1'b1;
      do begin
         @(negedge clk); got = close_ready;
         @(posedge clk); #2;
      end while (!got);
      close_valid = 1'b0;
      set_cfg(26'h3C3C3C3);   // scramble after capture (R10)
   endtask

   task automatic check_chan(input int start, input int n, input int base,
                             input logic [11:0] ea, input logic err, input string req);
      int nw;
      nw = (n + 2) / 3;
      chk({req, " R3 R4 header"}, cap_w[start], {2'b01, err, 3'b000, 10'(n), 4'b0000, ea});
      for (int w = 0; w < nw; w++) begin
         logic [31:0] e;
         e = '0;
         for (int k = 0; k < 3; k++) begin
            int idx;
            idx = w * 3 + k;
            if (idx < n) e[29 - 10*k -: 10] = 10'(base + idx);
         end
         chk({req, " R1 R2 sample word"}, cap_w[start + 1 + w], e);
      end
   endtask

   task automatic check_trailer(input int start, input int pay, input int amm,
                                input int lmm, input logic [25:0] v);
      logic [25:0] vals [9];
      vals[0] = 26'(pay);
      vals[1] = v ^ 26'h0ABCDEF;  vals[2] = v ^ 26'h1234567;
      vals[3] = {1'b0, 13'(lmm), 12'(amm)};
      vals[4] = v ^ 26'h000FFFF;  vals[5] = v ^ 26'h3FF0000;
      vals[6] = v ^ 26'h2AAAAAA;  vals[7] = v ^ 26'h1555555;
      vals[8] = {10'h002, v[8:0] ^ 9'h1A5, 7'd9};
      for (int i = 0; i < 9; i++) begin
         string req;
         case (i)
            0: req = "R7 payload count";
            3: req = "R8 mismatch counts";
            8: req = "R9 identity word";
            default: req = "R10 captured value";
         endcase
         chk({req, " R6 tag/code"}, cap_w[start + i],
             {(i == 8) ? 2'b11 : 2'b10, 4'(i), vals[i]});
         chk("R6 last flag", {31'b0, cap_l[start + i]}, {31'b0, (i == 8)});
      end
   endtask

   task automatic t_reset();
      chk("reset m_valid", {31'b0, m_valid}, 32'd0);
      chk("reset s_ready", {31'b0, s_ready}, 32'd1);
      chk("reset close_ready", {31'b0, close_ready}, 32'd1);
   endtask

   task automatic t_event_one();
      send_samples(7, 10, 1, 12'h123, 12'h123, 10'd7);
      wait_caps(4);
      check_chan(0, 7, 10, 12'h123, 1'b0, "R1 R2 match");
      send_samples(3, 500, 1, 12'h045, 12'h046, 10'd3);
      wait_caps(6);
      check_chan(4, 3, 500, 12'h045, 1'b1, "R4 address mismatch");
      send_samples(5, 1000, 1, 12'hFFF, 12'hFFF, 10'd6);
      wait_caps(9);
      check_chan(6, 5, 1000, 12'hFFF, 1'b1, "R4 length mismatch");
      set_cfg(26'h0000111);
      do_close();
      wait_caps(18);
      check_trailer(9, 9, 1, 1, 26'h0000111);
   endtask

   task automatic t_event_two();
      bp_en = 1'b1;
      send_samples(MAX_SAMP, 100, 0, 12'h0C3, 12'h0C3, 10'd16);
      wait_caps(25);
      check_chan(18, MAX_SAMP, 100, 12'h0C3, 1'b0, "R11 limit channel");
      send_samples(2, 300, 0, 12'h777, 12'h777, 10'd3);
      close_valid = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R6 close refused mid-channel", {31'b0, close_ready}, 32'd0);
      end
      @(posedge clk); #2;
      send_samples(1, 302, 1, 12'h777, 12'h777, 10'd3);
      wait_caps(27);
      check_chan(25, 3, 300, 12'h777, 1'b0, "R6 channel before close");
      set_cfg(26'h2220000);
      do_close();
      wait_caps(36);
      check_trailer(27, 9, 0, 0, 26'h2220000);
      bp_en = 1'b0;
      chk("R6 word count", 32'(cap_n), 32'd36);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      @(posedge clk); #2;
      t_event_one();
      t_event_two();
      repeat (5) @(posedge clk);
      report();
   end

endmodule